// File: doc/BRIEF.md
# Dual-Format DDR Lane Mapper

This block sits between a five-lane double-data-rate pin channel and a ten-bit internal word. Each clock period carries two five-bit samples, one for the rising half and one for the falling half of the period. A format input chooses how the ten bits are read. In code-group format they are one ten-bit symbol. In byte format they are eight data bits plus two control bits, and lane 4 carries control instead of data.

A speed input selects a low-rate nibble mode, which applies in byte format only. In this mode one byte takes two valid periods, the lower nibble first and the upper nibble second. Each nibble appears on both halves of its period. The two control bits are repeated in both periods.

The ingress path (pins to word) unpacks samples into words. In nibble mode it pairs two periods into one word and flags any inconsistency between them. A sync input realigns the pairing. The egress path (word to pins) does the reverse and spreads a byte over two periods when needed. Internal word layout in byte format: bits 7:0 data, bit 8 first control bit (rising half), bit 9 second control bit (falling half).

The ingress pairing machine has two states. ASM_LO waits for a lower nibble and moves to ASM_HI on a valid period. ASM_HI waits for the upper nibble, emits the word, and returns to ASM_LO. Sync, reset, or leaving nibble mode forces ASM_LO from either state.

The egress machine also has two states. SER_IDLE accepts a word. It moves to SER_UPPER only when a word arrives in nibble mode. SER_UPPER sends the stored upper nibble and always returns to SER_IDLE.

Top module: `ddr_lane_mapper`

## Requirements
- R1: Synchronous active-high reset clears every output to zero and returns both machines to ASM_LO and SER_IDLE. The first valid nibble-mode period after reset is taken as a lower nibble.
- R2: In code-group format (fmt_byte=0), a valid ingress period yields a word one clock later with wrd_o_vld high for that one cycle. The word is {pin_i_fall, pin_i_rise}, so bits 4:0 come from the rising half and bits 9:5 from the falling half.
- R3: In byte format at full rate, the ingress word is built as follows. Bits 3:0 come from pin_i_rise[3:0] and bits 7:4 from pin_i_fall[3:0]. Bit 8 is pin_i_rise[4] and bit 9 is pin_i_fall[4]. The word is valid one clock after the period.
- R4: In code-group format, a valid egress word drives pin_o_rise = word[4:0] and pin_o_fall = word[9:5] one clock later, with pin_o_vld high for one cycle.
- R5: In byte format at full rate, an egress word drives pin_o_rise = {word[8], word[3:0]} and pin_o_fall = {word[9], word[7:4]} one clock later.
- R6: In nibble mode (fmt_byte=1, slow_mode=1), ingress emits one word per two valid periods. The first period supplies bits 3:0, the second supplies bits 7:4, and the control bits come from the first period. The word is valid in the cycle after the second period. Cycles without pin_i_vld do not advance the pairing.
- R7: In nibble mode, wrd_o_err is raised together with the word in two cases: when the data lanes of the two halves of either period differ, or when lane 4 of the second period differs from that of the first in either half. wrd_o_err is never high without wrd_o_vld.
- R8: A period presented with nib_sync high in nibble mode is discarded. The next valid period is taken as a lower nibble.
- R9: In nibble mode an egress word is sent over two consecutive periods. The first carries word[3:0] and the second carries word[7:4]. The nibble is on lanes 3:0 of both halves, and lane 4 carries word[8] on the rising half and word[9] on the falling half in both periods.
- R10: An egress word presented while the upper nibble is being sent (SER_UPPER) is ignored; no third period follows.
- R11: slow_mode has no effect in code-group format; both paths stay at one word per valid cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fmt_byte | input | 1 | 0 = ten-bit code-group format, 1 = byte-plus-control format |
| slow_mode | input | 1 | 1 = low-rate nibble mode (byte format only) |
| nib_sync | input | 1 | Realigns ingress nibble pairing |
| pin_i_vld | input | 1 | Ingress period valid |
| pin_i_rise | input | 5 | Ingress rising-half sample |
| pin_i_fall | input | 5 | Ingress falling-half sample |
| wrd_o_vld | output | 1 | Ingress word valid, one cycle per word |
| wrd_o_data | output | 10 | Ingress word |
| wrd_o_err | output | 1 | Nibble-mode consistency error for the word |
| wrd_i_vld | input | 1 | Egress word valid |
| wrd_i_data | input | 10 | Egress word |
| pin_o_vld | output | 1 | Egress period valid |
| pin_o_rise | output | 5 | Egress rising-half sample |
| pin_o_fall | output | 5 | Egress falling-half sample |

## Verification
If the ingress pairing state were out of step, the next word after one nibble period would join the upper nibble of one byte with the lower nibble of the next. wrd_o_vld would then pulse one period early. Both effects are visible at the word output within two valid periods, which is why the bench checks strobe timing after each period and not only the final data. A stuck egress state would show up as a missing or repeated second period on pin_o_vld in the cycle right after the word is taken.

// File: rtl/ddr_map_pkg.sv
package ddr_map_pkg;
    typedef enum logic {ASM_LO, ASM_HI} asm_state_t;
    typedef enum logic {SER_IDLE, SER_UPPER} ser_state_t;
endpackage

// File: rtl/ddr_pin_unpack.sv
module ddr_pin_unpack
    import ddr_map_pkg::*;
#(
    parameter int LANE_W = 5
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                fmt_byte,
    input  logic                slow_en,
    input  logic                nib_sync,
    input  logic                pin_vld,
    input  logic [LANE_W-1:0]   pin_rise,
    input  logic [LANE_W-1:0]   pin_fall,
    output logic                wrd_vld,
    output logic [2*LANE_W-1:0] wrd_data,
    output logic                wrd_err
);
    localparam int NIB    = LANE_W - 1;
    localparam int WORD_W = 2 * LANE_W;

    asm_state_t state_q, state_d;

    logic              vld_q, err_q, c1_q, c2_q, perr_q;
    logic [WORD_W-1:0] data_q;
    logic [NIB-1:0]    lo_q;
    logic              edge_diff;
    logic [WORD_W-1:0] code_word, byte_word;

    assign edge_diff = pin_rise[NIB-1:0] != pin_fall[NIB-1:0];
    assign code_word = {pin_fall, pin_rise};
    assign byte_word = {pin_fall[NIB], pin_rise[NIB], pin_fall[NIB-1:0], pin_rise[NIB-1:0]};

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ASM_LO: if (slow_en && !nib_sync && pin_vld) state_d = ASM_HI;
            ASM_HI: if (!slow_en || nib_sync || pin_vld) state_d = ASM_LO;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ASM_LO;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q  <= 1'b0;
            err_q  <= 1'b0;
            data_q <= '0;
            lo_q   <= '0;
            c1_q   <= 1'b0;
            c2_q   <= 1'b0;
            perr_q <= 1'b0;
        end else begin
            vld_q <= 1'b0;
            err_q <= 1'b0;
            if (!slow_en) begin
                if (pin_vld) begin
                    vld_q  <= 1'b1;
                    data_q <= fmt_byte ? byte_word : code_word;
                end
            end else if (pin_vld && !nib_sync) begin
                unique case (state_q)
                    ASM_LO: begin
                        lo_q   <= pin_rise[NIB-1:0];
                        c1_q   <= pin_rise[NIB];
                        c2_q   <= pin_fall[NIB];
                        perr_q <= edge_diff;
                    end
                    ASM_HI: begin
                        vld_q  <= 1'b1;
                        data_q <= {c2_q, c1_q, pin_rise[NIB-1:0], lo_q};
                        err_q  <= perr_q | edge_diff
                                | (pin_rise[NIB] != c1_q) | (pin_fall[NIB] != c2_q);
                    end
                endcase
            end
        end
    end

    assign wrd_vld  = vld_q;
    assign wrd_data = data_q;
    assign wrd_err  = err_q;
endmodule

// File: rtl/ddr_word_pack.sv
module ddr_word_pack
    import ddr_map_pkg::*;
#(
    parameter int LANE_W = 5
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                fmt_byte,
    input  logic                slow_en,
    input  logic                wrd_vld,
    input  logic [2*LANE_W-1:0] wrd_data,
    output logic                pin_vld,
    output logic [LANE_W-1:0]   pin_rise,
    output logic [LANE_W-1:0]   pin_fall
);
    localparam int NIB    = LANE_W - 1;
    localparam int WORD_W = 2 * LANE_W;

    ser_state_t state_q, state_d;

    logic              vld_q, c1_q, c2_q;
    logic [LANE_W-1:0] rise_q, fall_q;
    logic [NIB-1:0]    up_q;
    logic              w_c1, w_c2;
    logic [NIB-1:0]    w_lo, w_hi;

    assign w_c1 = wrd_data[WORD_W-2];
    assign w_c2 = wrd_data[WORD_W-1];
    assign w_lo = wrd_data[NIB-1:0];
    assign w_hi = wrd_data[2*NIB-1:NIB];

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SER_IDLE:  if (slow_en && wrd_vld) state_d = SER_UPPER;
            SER_UPPER: state_d = SER_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= SER_IDLE;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q  <= 1'b0;
            rise_q <= '0;
            fall_q <= '0;
            up_q   <= '0;
            c1_q   <= 1'b0;
            c2_q   <= 1'b0;
        end else begin
            vld_q <= 1'b0;
            unique case (state_q)
                SER_IDLE: begin
                    if (wrd_vld) begin
                        vld_q <= 1'b1;
                        if (slow_en) begin
                            rise_q <= {w_c1, w_lo};
                            fall_q <= {w_c2, w_lo};
                            up_q   <= w_hi;
                            c1_q   <= w_c1;
                            c2_q   <= w_c2;
                        end else if (fmt_byte) begin
                            rise_q <= {w_c1, w_lo};
                            fall_q <= {w_c2, w_hi};
                        end else begin
                            rise_q <= wrd_data[LANE_W-1:0];
                            fall_q <= wrd_data[WORD_W-1:LANE_W];
                        end
                    end
                end
                SER_UPPER: begin
                    vld_q  <= 1'b1;
                    rise_q <= {c1_q, up_q};
                    fall_q <= {c2_q, up_q};
                end
            endcase
        end
    end

    assign pin_vld  = vld_q;
    assign pin_rise = rise_q;
    assign pin_fall = fall_q;
endmodule

// File: rtl/ddr_lane_mapper.sv
module ddr_lane_mapper #(
    parameter int LANE_W = 5
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                fmt_byte,
    input  logic                slow_mode,
    input  logic                nib_sync,
    input  logic                pin_i_vld,
    input  logic [LANE_W-1:0]   pin_i_rise,
    input  logic [LANE_W-1:0]   pin_i_fall,
    output logic                wrd_o_vld,
    output logic [2*LANE_W-1:0] wrd_o_data,
    output logic                wrd_o_err,
    input  logic                wrd_i_vld,
    input  logic [2*LANE_W-1:0] wrd_i_data,
    output logic                pin_o_vld,
    output logic [LANE_W-1:0]   pin_o_rise,
    output logic [LANE_W-1:0]   pin_o_fall
);
    logic slow_en;
    assign slow_en = fmt_byte & slow_mode;

    ddr_pin_unpack #(.LANE_W(LANE_W)) unpack_i (
        .clk      (clk),
        .rst      (rst),
        .fmt_byte (fmt_byte),
        .slow_en  (slow_en),
        .nib_sync (nib_sync),
        .pin_vld  (pin_i_vld),
        .pin_rise (pin_i_rise),
        .pin_fall (pin_i_fall),
        .wrd_vld  (wrd_o_vld),
        .wrd_data (wrd_o_data),
        .wrd_err  (wrd_o_err)
    );

    ddr_word_pack #(.LANE_W(LANE_W)) pack_i (
        .clk      (clk),
        .rst      (rst),
        .fmt_byte (fmt_byte),
        .slow_en  (slow_en),
        .wrd_vld  (wrd_i_vld),
        .wrd_data (wrd_i_data),
        .pin_vld  (pin_o_vld),
        .pin_rise (pin_o_rise),
        .pin_fall (pin_o_fall)
    );
endmodule

// File: rtl/ddr_lane_mapper_chk.sv
module ddr_lane_mapper_chk #(
    parameter int LANE_W = 5
) (
    input logic                clk,
    input logic                rst,
    input logic                fmt_byte,
    input logic                slow_mode,
    input logic                pin_i_vld,
    input logic [LANE_W-1:0]   pin_i_rise,
    input logic [LANE_W-1:0]   pin_i_fall,
    input logic                wrd_o_vld,
    input logic [2*LANE_W-1:0] wrd_o_data,
    input logic                wrd_o_err,
    input logic                pin_o_vld,
    input logic [LANE_W-1:0]   pin_o_rise,
    input logic [LANE_W-1:0]   pin_o_fall
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!wrd_o_vld && !wrd_o_err && !pin_o_vld && wrd_o_data == '0));

    // R2
    code_group_map_chk: assert property (@(posedge clk) disable iff (rst)
        (pin_i_vld && !fmt_byte) |=>
            (wrd_o_vld && wrd_o_data == {$past(pin_i_fall), $past(pin_i_rise)}));

    // R6
    nibble_pace_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(fmt_byte && slow_mode) && $past(fmt_byte && slow_mode, 2) && wrd_o_vld)
            |-> !$past(wrd_o_vld));

    // R7
    err_with_word_chk: assert property (@(posedge clk) disable iff (rst)
        wrd_o_err |-> wrd_o_vld);

    // R9
    egress_dup_chk: assert property (@(posedge clk) disable iff (rst)
        (pin_o_vld && $past(fmt_byte && slow_mode)) |->
            (pin_o_rise[LANE_W-2:0] == pin_o_fall[LANE_W-2:0]));
endmodule

bind ddr_lane_mapper ddr_lane_mapper_chk #(.LANE_W(LANE_W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .fmt_byte   (fmt_byte),
    .slow_mode  (slow_mode),
    .pin_i_vld  (pin_i_vld),
    .pin_i_rise (pin_i_rise),
    .pin_i_fall (pin_i_fall),
    .wrd_o_vld  (wrd_o_vld),
    .wrd_o_data (wrd_o_data),
    .wrd_o_err  (wrd_o_err),
    .pin_o_vld  (pin_o_vld),
    .pin_o_rise (pin_o_rise),
    .pin_o_fall (pin_o_fall)
);

// File: tb/ddr_lane_mapper_tb.sv
module ddr_lane_mapper_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int N_VEC = 7;

    // {fmt_byte, slow_mode, rise[4:0], fall[4:0], word[9:0]}
    localparam logic [21:0] VEC [N_VEC] = '{
        {1'b0, 1'b0, 5'h15, 5'h0A, 10'h155},
        {1'b0, 1'b0, 5'h1F, 5'h00, 10'h01F},
        {1'b0, 1'b1, 5'h03, 5'h1C, 10'h383},
        {1'b1, 1'b0, 5'h15, 5'h0A, 10'h1A5},
        {1'b1, 1'b0, 5'h0C, 5'h13, 10'h23C},
        {1'b1, 1'b0, 5'h1F, 5'h1F, 10'h3FF},
        {1'b1, 1'b0, 5'h00, 5'h10, 10'h200}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       fmt_byte = 1'b0, slow_mode = 1'b0, nib_sync = 1'b0;
    logic       pin_i_vld = 1'b0;
    logic [4:0] pin_i_rise = '0, pin_i_fall = '0;
    logic       wrd_o_vld, wrd_o_err;
    logic [9:0] wrd_o_data;
    logic       wrd_i_vld = 1'b0;
    logic [9:0] wrd_i_data = '0;
    logic       pin_o_vld;
    logic [4:0] pin_o_rise, pin_o_fall;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ddr_lane_mapper dut_i (
        .clk(clk), .rst(rst), .fmt_byte(fmt_byte), .slow_mode(slow_mode),
        .nib_sync(nib_sync), .pin_i_vld(pin_i_vld), .pin_i_rise(pin_i_rise),
        .pin_i_fall(pin_i_fall), .wrd_o_vld(wrd_o_vld), .wrd_o_data(wrd_o_data),
        .wrd_o_err(wrd_o_err), .wrd_i_vld(wrd_i_vld), .wrd_i_data(wrd_i_data),
        .pin_o_vld(pin_o_vld), .pin_o_rise(pin_o_rise), .pin_o_fall(pin_o_fall)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive_pins(input logic v, input logic [4:0] r, input logic [4:0] f);
        pin_i_vld  = v;
        pin_i_rise = r;
        pin_i_fall = f;
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) tick();
        // R1: reset state
        chk("R1 reset word_vld", {15'd0, wrd_o_vld}, 16'd0);
        chk("R1 reset word", {6'd0, wrd_o_data}, 16'd0);
        chk("R1 reset pins", {pin_o_vld, pin_o_rise, pin_o_fall}, 16'd0);
        rst = 1'b0;
        tick();

        // R2 R3 R4 R5 R11: vector table, ingress and egress in parallel
        for (int i = 0; i < N_VEC; i++) begin
            fmt_byte   = VEC[i][21];
            slow_mode  = VEC[i][20];
            drive_pins(1'b1, VEC[i][19:15], VEC[i][14:10]);
            wrd_i_vld  = 1'b1;
            wrd_i_data = VEC[i][9:0];
            tick();
            chk("R2/R3/R11 ingress word", {5'd0, wrd_o_vld, wrd_o_data}, {6'd1, VEC[i][9:0]});
            chk("R4/R5/R11 egress pins", {5'd0, pin_o_vld, pin_o_rise, pin_o_fall},
                {6'd1, VEC[i][19:10]});
        end
        drive_pins(1'b0, 5'h0, 5'h0);
        wrd_i_vld = 1'b0;
        tick();
        chk("R2 strobe single cycle", {14'd0, wrd_o_vld, pin_o_vld}, 16'd0);

        // R6: nibble-mode pairing with an idle gap, byte A5, c1=1 c2=0
        fmt_byte = 1'b1;
        slow_mode = 1'b1;
        drive_pins(1'b1, 5'h15, 5'h05);
        tick();
        chk("R6 no word after first nibble", {15'd0, wrd_o_vld}, 16'd0);
        drive_pins(1'b0, 5'h1F, 5'h1F);
        tick();
        chk("R6 idle does not advance", {15'd0, wrd_o_vld}, 16'd0);
        drive_pins(1'b1, 5'h1A, 5'h0A);
        tick();
        chk("R6 paired word", {4'd0, wrd_o_err, wrd_o_vld, wrd_o_data}, {4'd0, 1'b0, 1'b1, 10'h1A5});
        drive_pins(1'b0, 5'h0, 5'h0);
        tick();

        // R7: edge disagreement in first period
        drive_pins(1'b1, 5'h15, 5'h07);
        tick();
        drive_pins(1'b1, 5'h1A, 5'h0A);
        tick();
        chk("R7 edge mismatch err", {14'd0, wrd_o_err, wrd_o_vld}, 16'd3);
        // R7: control bit differs in second period
        drive_pins(1'b1, 5'h15, 5'h05);
        tick();
        drive_pins(1'b1, 5'h0A, 5'h0A);
        tick();
        chk("R7 ctrl mismatch err", {4'd0, wrd_o_err, wrd_o_vld, wrd_o_data}, {4'd0, 1'b1, 1'b1, 10'h1A5});
        drive_pins(1'b0, 5'h0, 5'h0);
        tick();

        // R8: sync discards its period and realigns
        drive_pins(1'b1, 5'h13, 5'h13);
        tick();
        nib_sync = 1'b1;
        drive_pins(1'b1, 5'h17, 5'h17);
        tick();
        nib_sync = 1'b0;
        chk("R8 sync period no word", {15'd0, wrd_o_vld}, 16'd0);
        drive_pins(1'b1, 5'h0C, 5'h1C);
        tick();
        chk("R8 realigned lower nibble", {15'd0, wrd_o_vld}, 16'd0);
        drive_pins(1'b1, 5'h03, 5'h13);
        tick();
        chk("R8 word after sync", {5'd0, wrd_o_vld, wrd_o_data}, {6'd1, 10'h23C});

        // R1: mid-pair reset, next valid period is a lower nibble
        drive_pins(1'b1, 5'h1F, 5'h1F);
        tick();
        drive_pins(1'b0, 5'h0, 5'h0);
        rst = 1'b1;
        tick();
        rst = 1'b0;
        drive_pins(1'b1, 5'h05, 5'h05);
        tick();
        chk("R1 phase cleared by reset", {15'd0, wrd_o_vld}, 16'd0);
        drive_pins(1'b1, 5'h06, 5'h06);
        tick();
        chk("R1 word after reset", {5'd0, wrd_o_vld, wrd_o_data}, {6'd1, 10'h065});
        drive_pins(1'b0, 5'h0, 5'h0);

        // R9 R10: egress nibble mode, second word during upper period ignored
        wrd_i_vld  = 1'b1;
        wrd_i_data = 10'h1A5;
        tick();
        chk("R9 lower period", {5'd0, pin_o_vld, pin_o_rise, pin_o_fall}, {6'd1, 5'h15, 5'h05});
        wrd_i_data = 10'h3FF;
        tick();
        chk("R9 upper period", {5'd0, pin_o_vld, pin_o_rise, pin_o_fall}, {6'd1, 5'h1A, 5'h0A});
        wrd_i_vld = 1'b0;
        tick();
        chk("R10 word in upper period ignored", {15'd0, pin_o_vld}, 16'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule